// File: doc/BRIEF.md
# Streaming SPI Slave Shift Port

This block is an 8-bit SPI slave data port for full-duplex streaming to a peer such as a PCM codec. The peer may hold the select line low for many bytes in a row. The port then moves byte after byte, with no select edge between them. SCK, MOSI and the active-low select are brought into the system clock through two-flop synchronisers. All SPI activity is decoded from edges of the synchronised samples. The interface uses SPI mode 0: MOSI is sampled on the rising SCK edge, MISO changes on the falling edge, and the MSB goes first.

Transmit and receive share one shift register. The host can preload the first transmit byte while the port is deselected. After each byte, the host gets a one-cycle completion pulse and the received byte in a buffer. The next transmit byte must be written in the short window between that pulse and the next falling SCK edge. If no byte is written in time, the shift register simply goes on and sends the byte it just received back out. A sticky flag records a completed byte that overwrote an unread one.

Top module: `spi_stream_slave`

## Requirements
- R1: While reset is held and after its release, `miso_o`, `miso_oe_o`, `byte_done_o`, `overrun_o` are 0 and `rx_data_o` is 0.
- R2: A `tx_wr_i` pulse while deselected loads the shift register. Once select is low, `miso_oe_o` is 1 and `miso_o` presents that byte MSB first, one bit per SCK period. Each bit is valid before the rising SCK edge, and MOSI is sampled on that rising edge.
- R3: Pulling select low, with no SCK activity, produces no `byte_done_o` pulse.
- R4: With select held low, consecutive 8-rise groups each complete a byte, each giving exactly one single-cycle `byte_done_o` pulse.
- R5: A `tx_wr_i` pulse after `byte_done_o` and before the next falling SCK edge makes the next byte on MISO equal to the written value.
- R6: With no write in that window, the next byte sent on MISO equals the byte just received on MOSI.
- R7: A `tx_wr_i` pulse after that falling edge does not change the byte in progress, and it does not change the byte that follows it.
- R8: `rx_data_o` takes the received byte in the same cycle `byte_done_o` rises. It changes at no other time, whatever `tx_wr_i` does.
- R9: With select high, `miso_o` and `miso_oe_o` are 0. Raising select mid-byte discards the partial byte: no pulse is produced, and the next full byte is received correctly.
- R10: The 8th rising SCK edge gives `byte_done_o` even if select rises immediately after it.
- R11: `overrun_o` is set when a byte completes while the previous one is still unread. A `rx_rd_i` pulse marks the buffer read. Once set, `overrun_o` stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | SPI serial clock from the master (idles low) |
| mosi_i | input | 1 | Serial data from the master |
| sel_n_i | input | 1 | Active-low select from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | MISO output enable (1 while selected) |
| tx_wr_i | input | 1 | Host write strobe for the transmit byte |
| tx_data_i | input | DATA_W | Host transmit byte |
| rx_rd_i | input | 1 | Host marks the received byte as read |
| rx_data_o | output | DATA_W | Last received byte |
| byte_done_o | output | 1 | One-cycle pulse after the last bit of a byte |
| overrun_o | output | 1 | Sticky flag: byte completed while previous unread |

## Verification
The main streaming function is driven with vector pairs whose transmit and receive bytes have opposite or mixed bit patterns (all ones against all zeros, alternating, mirrored). A swapped bit order, a shift off by one position or a mixed-up MISO and MOSI path therefore shows as a wrong byte rather than passing by coincidence. Runs with and without a host write in the reload window separate the preload path from the echo path. A write placed just after the closing edge shows whether the window closes at the right edge. Mid-byte deselection and deselection right after the 8th edge separate discarding a partial byte from losing a complete one.

// File: rtl/spi_stream_pkg.sv
// Package: types shared by the streaming SPI slave modules.
package spi_stream_pkg;
    // Decoded SCK transition events for one system clock cycle
    typedef struct packed {
        logic rise;
        logic fall;
    } sck_evt_t;
endpackage

// File: rtl/spi_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous bits.
// Assumes every bit is an independent level signal; no bus coherency.
module spi_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the asynchronous inputs through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_edge_det.sv
// Module: detects rising and falling transitions of synchronised SCK.
// Assumes SCK high and low phases each last at least two system clocks.
module spi_edge_det
    import spi_stream_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sck_s_i,
    output sck_evt_t evt_o
);
    logic sck_prev;

    // Remember the previous synchronised SCK level
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_s_i;
    end

    assign evt_o.rise = sck_s_i & ~sck_prev;
    assign evt_o.fall = ~sck_s_i & sck_prev;
endmodule

// File: rtl/spi_shift_core.sv
// Module: shared transmit/receive shift register with bit counter and the
// post-byte reload window. Mode 0: MOSI sampled on rise, shift on fall.
// Assumes SCK idles low; edges arrive as single-cycle events.
module spi_shift_core
    import spi_stream_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sck_evt_t          evt_i,
    input  logic              mosi_s_i,
    input  logic              active_i,
    input  logic              tx_wr_i,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic              miso_bit_o,
    output logic              done_stb_o,
    output logic [DATA_W-1:0] word_o
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] hold;
    logic [CNT_W-1:0]  cnt;
    logic              samp;
    logic              started;
    logic              win;
    logic              pend;

    assign done_stb_o = active_i & evt_i.rise & (cnt == LAST);
    assign word_o     = {shreg[DATA_W-2:0], mosi_s_i};
    assign miso_bit_o = shreg[DATA_W-1];

    // Keep the latest host transmit byte for a windowed reload
    always_ff @(posedge clk) begin
        if (!rst_n)       hold <= '0;
        else if (tx_wr_i) hold <= tx_data_i;
    end

    // Bit counting, sampling, shifting and reload window control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            cnt     <= '0;
            samp    <= 1'b0;
            started <= 1'b0;
            win     <= 1'b0;
            pend    <= 1'b0;
        end else if (!active_i) begin
            cnt     <= '0;
            started <= 1'b0;
            win     <= 1'b0;
            pend    <= 1'b0;
            if (tx_wr_i) shreg <= tx_data_i;
        end else begin
            if (evt_i.rise) begin
                samp    <= mosi_s_i;
                started <= 1'b1;
                if (cnt == LAST) begin
                    cnt <= '0;
                    win <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (evt_i.fall && started) begin
                win  <= 1'b0;
                pend <= 1'b0;
                if (pend)                shreg <= hold;
                else if (win && tx_wr_i) shreg <= tx_data_i;
                else                     shreg <= {shreg[DATA_W-2:0], samp};
            end
            if (tx_wr_i && !started)              shreg <= tx_data_i;
            if (tx_wr_i && win && !evt_i.fall)    pend  <= 1'b1;
        end
    end
endmodule

// File: rtl/spi_rx_buffer.sv
// Module: receive buffer, completion pulse and sticky overrun tracking.
// Assumes done_stb_i is a single-cycle strobe with word_i valid alongside.
module spi_rx_buffer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_stb_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] data_o,
    output logic              done_o,
    output logic              overrun_o
);
    logic full;

    // Capture the byte and raise the completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= done_stb_i;
            if (done_stb_i) data_o <= word_i;
        end
    end

    // Track unread data and latch overrun until reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full      <= 1'b0;
            overrun_o <= 1'b0;
        end else begin
            if (done_stb_i)  full <= 1'b1;
            else if (rd_i)   full <= 1'b0;
            if (done_stb_i && full && !rd_i) overrun_o <= 1'b1;
        end
    end
endmodule

// File: rtl/spi_stream_slave.sv
// Module: top of the streaming SPI slave port (mode 0, MSB first).
// Assumes clk runs at least 4x SCK and the master idles SCK low.
module spi_stream_slave
    import spi_stream_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              mosi_i,
    input  logic              sel_n_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    input  logic              tx_wr_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              rx_rd_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              byte_done_o,
    output logic              overrun_o
);
    logic [2:0]        sync_q;
    sck_evt_t          evt;
    logic              active;
    logic              miso_bit;
    logic              done_stb;
    logic [DATA_W-1:0] word;

    spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({sel_n_i, mosi_i, sck_i}), .q_o(sync_q)
    );

    spi_edge_det u_edge (
        .clk(clk), .rst_n(rst_n), .sck_s_i(sync_q[0]), .evt_o(evt)
    );

    assign active = ~sync_q[2];

    spi_shift_core #(.DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .mosi_s_i(sync_q[1]),
        .active_i(active), .tx_wr_i(tx_wr_i), .tx_data_i(tx_data_i),
        .miso_bit_o(miso_bit), .done_stb_o(done_stb), .word_o(word)
    );

    spi_rx_buffer #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .done_stb_i(done_stb), .word_i(word),
        .rd_i(rx_rd_i), .data_o(rx_data_o), .done_o(byte_done_o),
        .overrun_o(overrun_o)
    );

    assign miso_oe_o = active;
    assign miso_o    = active & miso_bit;
endmodule

// File: rtl/spi_stream_slave_chk.sv
// Module: protocol checker for spi_stream_slave, attached through bind.
module spi_stream_slave_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_rd_i,
    input logic [DATA_W-1:0] rx_data_o,
    input logic              byte_done_o,
    input logic              overrun_o
);
    // R4
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done_o |=> !byte_done_o);

    // R8
    rx_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data_o) |-> byte_done_o);

    // R11
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

    // R11
    overrun_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_o) |-> byte_done_o);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!byte_done_o && !overrun_o && rx_data_o == '0));
endmodule

bind spi_stream_slave spi_stream_slave_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_rd_i(rx_rd_i), .rx_data_o(rx_data_o),
    .byte_done_o(byte_done_o), .overrun_o(overrun_o)
);

// File: tb/tb_spi_stream_slave.sv
module tb_spi_stream_slave;
    localparam int HALF = 8;
    localparam logic [15:0] VEC [4] = '{16'hA53C, 16'h00FF, 16'hFF00, 16'h817E};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, mosi = 1'b0, sel_n = 1'b1;
    logic       tx_wr = 1'b0, rx_rd = 1'b0;
    logic [7:0] tx_data = '0;
    logic       miso_o, miso_oe_o, byte_done_o, overrun_o;
    logic [7:0] rx_data_o;
    int         n_chk = 0, n_bad = 0, done_cnt = 0;
    bit         finished = 1'b0;
    logic [7:0] got;

    always #10 clk = ~clk;

    spi_stream_slave dut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .mosi_i(mosi), .sel_n_i(sel_n),
        .miso_o(miso_o), .miso_oe_o(miso_oe_o), .tx_wr_i(tx_wr),
        .tx_data_i(tx_data), .rx_rd_i(rx_rd), .rx_data_o(rx_data_o),
        .byte_done_o(byte_done_o), .overrun_o(overrun_o)
    );

    always @(posedge clk) if (rst_n && byte_done_o) done_cnt++;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        tx_data = v; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic rd();
        rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
    endtask

    // one byte: rl writes nx in the window, drop raises select after 8th rise
    task automatic xfer(input logic [7:0] m, input bit rl, input logic [7:0] nx,
                        input bit drop, output logic [7:0] g);
        for (int i = 7; i >= 0; i--) begin
            mosi = m[i];
            repeat (HALF) @(negedge clk);
            g[i] = miso_o;
            sck = 1'b1;
            if (i == 0 && drop) begin @(negedge clk); sel_n = 1'b1; repeat (4) @(negedge clk); end
            else repeat (5) @(negedge clk);
            if (i == 0 && rl) begin wr(nx); repeat (2) @(negedge clk); end
            else repeat (3) @(negedge clk);
            sck = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int d0;
        repeat (4) @(negedge clk);
        // R1 reset state, during and after reset
        check("R1 miso", miso_o, 0); check("R1 oe", miso_oe_o, 0);
        rst_n = 1'b1; repeat (4) @(negedge clk);
        check("R1 done", byte_done_o, 0); check("R1 ovr", overrun_o, 0);
        check("R1 rx", rx_data_o, 0); check("R1 oe2", miso_oe_o, 0);

        // R2 preload then select; R3 select alone gives no pulse
        wr(VEC[0][15:8]);
        sel_n = 1'b0; repeat (20) @(negedge clk);
        check("R3 no pulse on select", done_cnt, 0);
        check("R2 oe", miso_oe_o, 1);
        check("R2 first msb", miso_o, VEC[0][15]);

        // R2 R4 R5 R8 streaming table
        for (int k = 0; k < 4; k++) begin
            d0 = done_cnt;
            xfer(VEC[k][7:0], k < 3, (k < 3) ? VEC[(k + 1) % 4][15:8] : 8'h00, 1'b0, got);
            check("R2/R5 miso byte", got, VEC[k][15:8]);
            check("R8 rx byte", rx_data_o, VEC[k][7:0]);
            check("R4 one pulse", done_cnt - d0, 1);
            rd();
        end

        // R6 echo without reload
        xfer(8'h5A, 1'b0, 8'h00, 1'b0, got);
        check("R6 echo", got, 8'h7E); rd();

        // R7 write just after the closing edge is ignored
        repeat (6) @(negedge clk); wr(8'h99);
        xfer(8'hC3, 1'b0, 8'h00, 1'b0, got);
        check("R7 byte in progress", got, 8'h5A);
        check("R8 rx after write", rx_data_o, 8'hC3); rd();
        xfer(8'h11, 1'b0, 8'h00, 1'b0, got);
        check("R7 following byte", got, 8'hC3); rd();

        // R10 select rises right after 8th edge
        d0 = done_cnt;
        xfer(8'h6B, 1'b0, 8'h00, 1'b1, got);
        check("R10 pulse", done_cnt - d0, 1);
        check("R10 rx", rx_data_o, 8'h6B); rd();
        check("R9 miso idle", miso_o, 0); check("R9 oe idle", miso_oe_o, 0);

        // R9 partial byte discarded
        d0 = done_cnt;
        wr(8'hE7); sel_n = 1'b0; repeat (10) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            mosi = i[0]; repeat (HALF) @(negedge clk); sck = 1'b1;
            repeat (HALF) @(negedge clk); sck = 1'b0;
        end
        repeat (4) @(negedge clk); sel_n = 1'b1; repeat (10) @(negedge clk);
        check("R9 no pulse partial", done_cnt - d0, 0);
        wr(8'hE7); sel_n = 1'b0; repeat (10) @(negedge clk);
        xfer(8'h24, 1'b0, 8'h00, 1'b0, got);
        check("R9 miso after partial", got, 8'hE7);
        check("R9 rx after partial", rx_data_o, 8'h24); rd();

        // R11 overrun
        xfer(8'h01, 1'b0, 8'h00, 1'b0, got);
        check("R11 no overrun yet", overrun_o, 0);
        xfer(8'h02, 1'b0, 8'h00, 1'b0, got);
        check("R11 overrun set", overrun_o, 1);
        rd(); repeat (3) @(negedge clk);
        check("R11 overrun sticky", overrun_o, 1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule